// File: doc/BRIEF.md
# Multiplexed-Address Byte ROM Read Sequencer

This block turns one 32-bit read from a host bus into four 8-bit reads from an external parallel ROM. The ROM sits behind one shared 8-bit address bus. The high address byte goes out first and is captured by an external latch when the block pulses a latch clock. The same bus then carries the low address byte. Every step runs on the host bus clock.

The high byte is latched once per request and serves all four byte reads. For each byte the block puts a low address on the bus and waits a programmable number of clocks. It then samples the ROM data inputs on the edge that also moves the bus to the next low address. The first three bytes are kept in holding registers. The fourth byte goes straight from the data inputs to the top byte of the host data word. The block then gives the host a one-cycle data-ready pulse and drops the ROM output enable two clocks later.

The host logic decides when a read is claimed and raises `req_start` in that cycle. The byte-wait setting is loaded through `cfg_we` and takes effect from the next read.

Top module: `rom_byte_fetch`

## Requirements
- R1: While reset is held, `rom_oe_o`, `rom_le_o`, `host_ready_o` and `busy_o` are 0 and `rom_ad_o` is 0. The byte-wait setting resets to 9.
- R2: In a cycle where the block is idle and `req_start` is 1, `rom_ad_o` shows the high address byte (`req_addr[15:8]`) in that same cycle. The request is accepted at the closing edge of that cycle.
- R3: In the cycle after acceptance, `rom_oe_o` and `rom_le_o` are both 1 and `rom_ad_o` still shows the high byte. In the next cycle `rom_le_o` is 0, the high byte is still on the bus, and the output enable stays 1. The latch clock pulses exactly once per request.
- R4: Starting three cycles after the acceptance cycle, the bus carries the low address byte `{req_addr[7:2], k}` for byte k = 0, 1, 2, 3 in that order. The high byte is not driven again for that request.
- R5: Each low address is held for W clocks, where W is the byte-wait setting and a setting of 0 acts as 1. The data byte is sampled on the edge that ends the last of those clocks, and that same edge puts the next low address on the bus.
- R6: Byte k lands in host data bits [8k+7:8k]. Bits 31:24 follow `rom_d_i` combinationally while `host_ready_o` is 1. `host_data_o` is 0 while `host_ready_o` is 0.
- R7: `host_ready_o` is 1 for exactly one cycle, the cycle right after the fourth sample edge. That is cycle 3+4W counted from the acceptance cycle as cycle 0.
- R8: `rom_oe_o` and `busy_o` stay 1 for the cycle after the ready cycle. Both are 0 two cycles after the ready cycle.
- R9: `req_start` has no effect while `busy_o` is 1. The addresses, the data word and the timing of the read in progress are unchanged.
- R10: A byte-wait value written with `cfg_we` sets W for every later read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load the byte-wait setting |
| cfg_wait | input | 4 | New byte-wait value, in clocks |
| req_start | input | 1 | Host read claimed this cycle |
| req_addr | input | 14 | ROM word address, byte address bits 15:2 |
| busy_o | output | 1 | A request is in progress |
| host_ready_o | output | 1 | One-cycle data-ready pulse to the host |
| host_data_o | output | 32 | Assembled ROM word |
| rom_ad_o | output | 8 | Shared high/low ROM address bus |
| rom_le_o | output | 1 | Clock for the external high-address latch |
| rom_oe_o | output | 1 | ROM output enable |
| rom_d_i | input | 8 | ROM data byte |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, four bytes per word, a 4-bit wait field and a reset wait of 9. The full wait field can therefore be programmed. Reads run with the reset value and then with waits of 1, 0, 15 and 3. This covers the single-clock wait, the zero-to-one mapping and the longest wait. The ROM model returns a wrong byte until the low address has been stable for W clocks, so a sample taken one clock early or late changes the word. One read overrides the data inputs during the ready cycle to show the fourth byte's direct path. Another raises a new request in the middle of a fetch.

// File: rtl/rom_fetch_pkg.sv
package rom_fetch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LATCH,
    ST_HOLD,
    ST_FETCH,
    ST_READY,
    ST_RELEASE
  } fetch_state_t;

  // Clocks one low address is held; a programmed zero acts as one.
  function automatic int unsigned eff_wait(input int unsigned setting);
    return (setting == 0) ? 1 : setting;
  endfunction

endpackage

// File: rtl/rom_fetch_timer.sv
module rom_fetch_timer
  import rom_fetch_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WAIT_W-1:0] wait_val,
  output logic              expire
);

  logic [WAIT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= WAIT_W'(eff_wait(32'(wait_val)) - 1);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expire = (cnt == '0);

  // R5: after a load the count only falls or stays at zero
  a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && $past(!load) && cnt != '0) |-> $past(cnt) != '0);

endmodule

// File: rtl/rom_fetch_ctrl.sv
module rom_fetch_ctrl
  import rom_fetch_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int IDX_W = $clog2(NBYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic             expire,
  output fetch_state_t     state,
  output logic [IDX_W-1:0] idx,
  output logic             take,
  output logic             load,
  output logic             sample,
  output logic             last_byte
);

  fetch_state_t state_nx;

  assign take      = (state == ST_IDLE) && req_start;
  assign last_byte = (idx == IDX_W'(NBYTES - 1));
  assign sample    = (state == ST_FETCH) && expire;
  assign load      = (state == ST_HOLD) || (sample && !last_byte);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:    if (req_start) state_nx = ST_LATCH;
      ST_LATCH:   state_nx = ST_HOLD;
      ST_HOLD:    state_nx = ST_FETCH;
      ST_FETCH:   if (sample && last_byte) state_nx = ST_READY;
      ST_READY:   state_nx = ST_RELEASE;
      ST_RELEASE: state_nx = ST_IDLE;
      default:    state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_HOLD)             idx <= '0;
      else if (sample && !last_byte)    idx <= idx + 1'b1;
    end
  end

  // R3: the hold cycle always follows the latch cycle
  a_r3_hold_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> $past(state) == ST_LATCH);

  // R7: ready follows the sample of the final byte
  a_r7_ready_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READY) |-> $past(sample && last_byte));

endmodule

// File: rtl/rom_fetch_assemble.sv
module rom_fetch_assemble #(
  parameter int BUS_W  = 8,
  parameter int NBYTES = 4,
  localparam int IDX_W  = $clog2(NBYTES),
  localparam int WORD_W = BUS_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample,
  input  logic [IDX_W-1:0]  idx,
  input  logic              ready,
  input  logic [BUS_W-1:0]  rom_d,
  output logic [WORD_W-1:0] word
);

  logic [BUS_W-1:0] hold [NBYTES-1];

  for (genvar k = 0; k < NBYTES - 1; k++) begin : g_hold
    always_ff @(posedge clk) begin
      if (!rst_n)                               hold[k] <= '0;
      else if (sample && idx == IDX_W'(k))      hold[k] <= rom_d;
    end
    assign word[k*BUS_W +: BUS_W] = ready ? hold[k] : '0;
  end

  // Final byte passes straight through while ready is shown.
  assign word[WORD_W-1 -: BUS_W] = ready ? rom_d : '0;

endmodule

// File: rtl/rom_byte_fetch.sv
module rom_byte_fetch
  import rom_fetch_pkg::*;
#(
  parameter int BUS_W    = 8,
  parameter int NBYTES   = 4,
  parameter int WAIT_W   = 4,
  parameter int WAIT_RST = 9,
  localparam int ADDR_W  = 2 * BUS_W,
  localparam int IDX_W   = $clog2(NBYTES),
  localparam int WORD_W  = BUS_W * NBYTES
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [WAIT_W-1:0]       cfg_wait,
  input  logic                    req_start,
  input  logic [ADDR_W-1:IDX_W]   req_addr,
  output logic                    busy_o,
  output logic                    host_ready_o,
  output logic [WORD_W-1:0]       host_data_o,
  output logic [BUS_W-1:0]        rom_ad_o,
  output logic                    rom_le_o,
  output logic                    rom_oe_o,
  input  logic [BUS_W-1:0]        rom_d_i
);

  fetch_state_t           state;
  logic [IDX_W-1:0]       idx;
  logic                   take, load, sample, last_byte, expire;
  logic [WAIT_W-1:0]      wait_q;
  logic [ADDR_W-1:IDX_W]  addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      wait_q <= WAIT_W'(WAIT_RST);
    else if (cfg_we) wait_q <= cfg_wait;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= '0;
    else if (take) addr_q <= req_addr;
  end

  rom_fetch_ctrl #(.NBYTES(NBYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .expire(expire),
    .state(state), .idx(idx), .take(take), .load(load),
    .sample(sample), .last_byte(last_byte)
  );

  rom_fetch_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load), .wait_val(wait_q), .expire(expire)
  );

  rom_fetch_assemble #(.BUS_W(BUS_W), .NBYTES(NBYTES)) u_asm (
    .clk(clk), .rst_n(rst_n), .sample(sample), .idx(idx),
    .ready(host_ready_o), .rom_d(rom_d_i), .word(host_data_o)
  );

  always_comb begin
    case (state)
      ST_IDLE:           rom_ad_o = take ? req_addr[ADDR_W-1:BUS_W] : '0;
      ST_LATCH, ST_HOLD: rom_ad_o = addr_q[ADDR_W-1:BUS_W];
      default:           rom_ad_o = {addr_q[BUS_W-1:IDX_W], idx};
    endcase
  end

  assign busy_o       = (state != ST_IDLE);
  assign rom_oe_o     = busy_o;
  assign rom_le_o     = (state == ST_LATCH);
  assign host_ready_o = (state == ST_READY);

  // R3: latch clock lasts one cycle and only with output enable
  a_r3_le_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rom_le_o |=> !rom_le_o);
  a_r3_le_with_oe: assert property (@(posedge clk) disable iff (!rst_n)
    rom_le_o |-> rom_oe_o);
  // R5: the low address only moves on a sample edge
  a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FETCH && !sample) |=> $stable(rom_ad_o));
  a_r5_addr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && !last_byte) |=> rom_ad_o != $past(rom_ad_o));
  // R7: ready is a single-cycle pulse
  a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready_o |=> !host_ready_o);
  // R8: enable held one cycle past ready, dropped the cycle after
  a_r8_oe_hold: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready_o |=> rom_oe_o);
  a_r8_oe_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $past(host_ready_o, 2) |-> !rom_oe_o);
  // R9: a request while busy leaves the captured address alone
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && req_start) |=> $stable(addr_q));

endmodule

// File: tb/rom_byte_fetch_tb.sv
module rom_byte_fetch_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_wait = '0;
  logic        req_start = 1'b0;
  logic [15:2] req_addr = '0;
  logic        busy_o, host_ready_o, rom_le_o, rom_oe_o;
  logic [31:0] host_data_o;
  logic [7:0]  rom_ad_o, rom_d_i;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rom_byte_fetch u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wait(cfg_wait),
    .req_start(req_start), .req_addr(req_addr), .busy_o(busy_o),
    .host_ready_o(host_ready_o), .host_data_o(host_data_o),
    .rom_ad_o(rom_ad_o), .rom_le_o(rom_le_o), .rom_oe_o(rom_oe_o),
    .rom_d_i(rom_d_i)
  );

  // ROM model: external latch, slow device, data valid after model_wait clocks.
  logic [7:0]  latch_hi = '0;
  logic [7:0]  prev_ad  = '0;
  int unsigned age = 0;
  int unsigned stable_now;
  int unsigned model_wait = 9;
  bit          ovr_en = 0;
  logic [7:0]  ovr_val = '0;

  function automatic logic [7:0] rom_byte(input logic [7:0] hi, input logic [7:0] lo);
    return (hi ^ 8'h5A) + 8'(lo * 8'd3);
  endfunction

  always @(negedge rom_le_o) latch_hi <= rom_ad_o;
  assign stable_now = (rom_ad_o == prev_ad) ? age + 1 : 1;
  always @(posedge clk) begin
    prev_ad <= rom_ad_o;
    age     <= stable_now;
  end
  assign rom_d_i = ovr_en ? ovr_val :
                   (rom_oe_o && stable_now >= model_wait) ? rom_byte(latch_hi, rom_ad_o) : 8'hA5;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_wait(input logic [3:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wait = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rom_oe_o === 1'b0 && rom_le_o === 1'b0, "R1", "enable/latch in reset",
        {30'd0, rom_oe_o, rom_le_o}, 32'd0);
    chk(host_ready_o === 1'b0 && busy_o === 1'b0, "R1", "ready/busy in reset",
        {30'd0, host_ready_o, busy_o}, 32'd0);
    chk(rom_ad_o === 8'h00, "R1", "bus in reset", {24'd0, rom_ad_o}, 32'd0);
    rst_n = 1'b1;
  endtask

  // One full read; w is the programmed wait, inject raises req mid-fetch,
  // probe overrides the data inputs during the ready cycle.
  task automatic do_read(input logic [15:0] addr, input int unsigned w,
                         input bit inject, input bit probe);
    int unsigned ew;
    logic [7:0]  hi;
    logic [31:0] exp_word;
    logic [7:0]  exp_ad;
    bit ad_ok, le_ok, rdy_ok, oe_ok;
    ew = (w == 0) ? 1 : w;
    hi = addr[15:8];
    model_wait = ew;
    for (int k = 0; k < 4; k++)
      exp_word[k*8 +: 8] = rom_byte(hi, {addr[7:2], 2'(k)});
    ad_ok = 1; le_ok = 1; rdy_ok = 1; oe_ok = 1;

    @(negedge clk);
    req_start = 1'b1; req_addr = addr[15:2];
    #1;
    chk(rom_ad_o === hi && busy_o === 1'b0, "R2", "high byte in claim cycle",
        {23'd0, busy_o, rom_ad_o}, {24'd0, hi});

    @(negedge clk);
    req_start = 1'b0;
    chk(rom_le_o === 1'b1 && rom_oe_o === 1'b1 && rom_ad_o === hi, "R3",
        "latch cycle", {22'd0, rom_le_o, rom_oe_o, rom_ad_o}, {22'd0, 2'b11, hi});

    @(negedge clk);
    chk(rom_le_o === 1'b0 && rom_oe_o === 1'b1 && rom_ad_o === hi, "R3",
        "hold cycle", {22'd0, rom_le_o, rom_oe_o, rom_ad_o}, {22'd0, 2'b01, hi});

    for (int c = 3; c < 3 + 4 * int'(ew); c++) begin
      @(negedge clk);
      exp_ad = {addr[7:2], 2'((c - 3) / int'(ew))};
      if (rom_ad_o !== exp_ad) ad_ok = 0;
      if (rom_le_o !== 1'b0)   le_ok = 0;
      if (host_ready_o !== 1'b0) rdy_ok = 0;
      if (rom_oe_o !== 1'b1)   oe_ok = 0;
      if (inject && c == 5) begin req_start = 1'b1; req_addr = 14'h3FFF; end
      if (inject && c == 6) req_start = 1'b0;
    end
    req_start = 1'b0;
    chk(ad_ok, "R4 R5", "low address sequence and hold", {31'd0, ad_ok}, 32'd1);
    chk(le_ok && oe_ok, "R3", "single latch pulse, enable held",
        {30'd0, le_ok, oe_ok}, 32'd3);
    chk(rdy_ok, "R7", "no early ready", {31'd0, rdy_ok}, 32'd1);

    @(negedge clk);
    chk(host_ready_o === 1'b1, "R7", "ready at 3+4W", {31'd0, host_ready_o}, 32'd1);
    chk(host_data_o === exp_word, inject ? "R9" : "R6", "assembled word",
        host_data_o, exp_word);
    if (probe) begin
      ovr_en = 1; ovr_val = ~exp_word[31:24];
      #1;
      chk(host_data_o === {ovr_val, exp_word[23:0]}, "R6", "fourth byte passthrough",
          host_data_o, {ovr_val, exp_word[23:0]});
      ovr_en = 0;
    end

    @(negedge clk);
    chk(host_ready_o === 1'b0 && rom_oe_o === 1'b1 && busy_o === 1'b1 &&
        host_data_o === 32'd0, "R8", "release cycle",
        {29'd0, host_ready_o, rom_oe_o, busy_o}, 32'd3);

    @(negedge clk);
    chk(rom_oe_o === 1'b0 && busy_o === 1'b0, "R8", "enable dropped",
        {30'd0, rom_oe_o, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    check_reset();
    do_read(16'h12A4, 9, 0, 0);   // R1 reset wait 9, R10 default
    set_wait(4'd1);
    do_read(16'h3C10, 1, 0, 0);   // R10 shortest wait
    set_wait(4'd0);
    do_read(16'h80FC, 0, 0, 0);   // R5 zero acts as one
    set_wait(4'd15);
    do_read(16'h0148, 15, 0, 1);  // R6 passthrough probe, longest wait
    set_wait(4'd3);
    do_read(16'hE730, 3, 1, 0);   // R9 request while busy
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule